// File: doc/BRIEF.md
# Line Loss-of-Signal Density Detector

This block watches the recovered bit stream of a line receiver and decides, from its mark and zero content alone, whether the line has lost its signal. A run of consecutive zeros longer than a threshold declares loss. Loss is released only once a sliding window of recent bits carries enough marks and contains no over-long zero run. Three criteria are supported: one for the 1.544 Mbit/s (T1) rate and two for the 2.048 Mbit/s (E1) rate, a short one and a long one of about one millisecond.

Bits arrive one at a time with a bit enable, so the block can sit behind a clock-recovery stage that does not produce a bit every cycle. An analog amplitude detector outside the block may report loss on its own; that result is ORed into the line-loss output but not into the density status. An interrupt flag is raised on every change of the line-loss output unless masked, and software clears it with a one-cycle pulse.

Top module: `line_los_detector`

## Requirements
- R1: After reset `losOut`, `losStatus` and `losIrq` are all 0.
- R2: With `e1Mode`=0 (T1 criterion), `losOut` and `losStatus` become 1 two clock edges after the enabled bit that completes a run of 175 consecutive zeros; a run of 174 zeros does not declare loss.
- R3: Under the T1 criterion, loss is cleared two edges after the enabled bit at which the last 128 enabled bits hold at least 16 marks and none of those 128 bits was the 100th or later zero of a zero run; fewer marks, or such a long run inside the window, keeps loss set.
- R4: With `e1Mode`=1 and the short E1 criterion selected, loss is declared two edges after the enabled bit completing 32 consecutive zeros, and not after 31.
- R5: Under either E1 criterion, loss is cleared two edges after the enabled bit at which the last 32 enabled bits hold at least 4 marks and none of them was the 16th or later zero of a zero run.
- R6: With `e1Mode`=1, `altStd`=1 and `hwMode`=0 (long E1 criterion), loss is declared after 2048 consecutive zeros and not after 2047.
- R7: With `hwMode`=1 the short E1 criterion is used whenever `e1Mode`=1, whatever `altStd` is.
- R8: A cycle with `bitValid`=0 is ignored: it neither extends nor breaks a zero run and does not enter the window.
- R9: `losOut` is 1 one edge after `ampLos` is sampled high, while `losStatus` reflects only the density criterion.
- R10: `losIrq` is set on the edge at which `losOut` changes value if `intMask` was 0 at that edge; with `intMask`=1 no change sets it.
- R11: `losIrq` stays set until an edge with `intClr`=1 clears it; if a change of `losOut` happens at the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Enables the bit on `rxBit` this cycle |
| rxBit | input | 1 | Recovered bit, 1 is a mark |
| e1Mode | input | 1 | 0 selects the T1 criterion, 1 an E1 criterion |
| altStd | input | 1 | With `e1Mode`=1, 1 selects the long E1 criterion |
| hwMode | input | 1 | 1 restricts the choice to T1 and short E1 |
| ampLos | input | 1 | Loss reported by the amplitude detector |
| intMask | input | 1 | 1 suppresses setting of the interrupt flag |
| intClr | input | 1 | One-cycle pulse clearing the interrupt flag |
| losOut | output | 1 | Line loss: density loss OR amplitude loss |
| losStatus | output | 1 | Density-criterion loss state |
| losIrq | output | 1 | Sticky interrupt flag on each change of `losOut` |

## Verification
An enabled bit is registered into the run and window counters at one edge, and the loss decision taken from those counters lands at the next, so each density result is due two edges after its bit; `ampLos` and `intClr` act one edge after they are sampled. The driver pushes one expected item per enabled bit and the monitor compares it only once a two-stage copy of the bit enable shows that the bit's result is due, sampling on the falling edge. The one-edge paths are checked by directed steps that drive on a falling edge and compare on the next one, with the bit stream idle.

// File: rtl/line_los_pkg.sv
package line_los_pkg;

  typedef enum logic [1:0] {
    CRIT_T1       = 2'd0,
    CRIT_E1_SHORT = 2'd1,
    CRIT_E1_LONG  = 2'd2
  } losCrit_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // accept rxBit this cycle
    logic t1Win;    // apply the long-window run limit
  } dpStrobe_t;

endpackage

// File: rtl/line_los_datapath.sv
module line_los_datapath
  import line_los_pkg::*;
#(
  parameter int LONG_WIN      = 128,
  parameter int SHORT_WIN     = 32,
  parameter int LONG_RUN_MAX  = 99,
  parameter int SHORT_RUN_MAX = 15,
  parameter int RUN_SAT       = 2048,
  localparam int RUN_W        = $clog2(RUN_SAT + 1),
  localparam int MARK_W       = $clog2(LONG_WIN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              rxBit,
  output logic [RUN_W-1:0]  zeroRun,
  output logic [MARK_W-1:0] longMarks,
  output logic [MARK_W-1:0] shortMarks,
  output logic [MARK_W-1:0] cleanAge
);

  logic [LONG_WIN-1:0] history;
  logic [RUN_W-1:0]    runLimit;
  logic                runTooLong;

  always_comb begin
    runLimit   = strobe.t1Win ? RUN_W'(LONG_RUN_MAX) : RUN_W'(SHORT_RUN_MAX);
    // the incoming zero would be past the allowed run length
    runTooLong = !rxBit && (zeroRun >= runLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      history    <= '0;
      zeroRun    <= '0;
      longMarks  <= '0;
      shortMarks <= '0;
      cleanAge   <= '0;
    end else if (strobe.shiftEn) begin
      history    <= {history[LONG_WIN-2:0], rxBit};
      longMarks  <= longMarks + MARK_W'(rxBit) - MARK_W'(history[LONG_WIN-1]);
      shortMarks <= shortMarks + MARK_W'(rxBit) - MARK_W'(history[SHORT_WIN-1]);
      if (rxBit)
        zeroRun <= '0;
      else if (zeroRun != RUN_W'(RUN_SAT))
        zeroRun <= zeroRun + 1'b1;
      if (runTooLong)
        cleanAge <= '0;
      else if (cleanAge != MARK_W'(LONG_WIN))
        cleanAge <= cleanAge + 1'b1;
    end
  end

endmodule

// File: rtl/line_los_ctrl.sv
module line_los_ctrl
  import line_los_pkg::*;
#(
  parameter int LONG_WIN        = 128,
  parameter int SHORT_WIN       = 32,
  parameter int LONG_MIN_MARKS  = 16,
  parameter int SHORT_MIN_MARKS = 4,
  parameter int T1_DECL         = 175,
  parameter int E1_SHORT_DECL   = 32,
  parameter int E1_LONG_DECL    = 2048,
  parameter int RUN_W           = 12,
  parameter int MARK_W          = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              e1Mode,
  input  logic              altStd,
  input  logic              hwMode,
  input  logic              ampLos,
  input  logic              intMask,
  input  logic              intClr,
  input  logic [RUN_W-1:0]  zeroRun,
  input  logic [MARK_W-1:0] longMarks,
  input  logic [MARK_W-1:0] shortMarks,
  input  logic [MARK_W-1:0] cleanAge,
  output dpStrobe_t         strobe,
  output logic              losDens,
  output logic              losOut,
  output logic              losIrq
);

  losCrit_e         crit;
  logic [RUN_W-1:0] declThr;
  logic             declareHit;
  logic             clearHit;
  logic             nextDens;
  logic             nextOut;

  always_comb begin
    if (!e1Mode)
      crit = CRIT_T1;
    else if (altStd && !hwMode)
      crit = CRIT_E1_LONG;
    else
      crit = CRIT_E1_SHORT;

    case (crit)
      CRIT_T1:      declThr = RUN_W'(T1_DECL);
      CRIT_E1_LONG: declThr = RUN_W'(E1_LONG_DECL);
      default:      declThr = RUN_W'(E1_SHORT_DECL);
    endcase

    declareHit = zeroRun >= declThr;
    if (crit == CRIT_T1)
      clearHit = (longMarks >= MARK_W'(LONG_MIN_MARKS)) && (cleanAge >= MARK_W'(LONG_WIN));
    else
      clearHit = (shortMarks >= MARK_W'(SHORT_MIN_MARKS)) && (cleanAge >= MARK_W'(SHORT_WIN));

    nextDens = losDens ? !clearHit : declareHit;
    nextOut  = nextDens || ampLos;

    strobe.shiftEn = bitValid;
    strobe.t1Win   = (crit == CRIT_T1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      losDens <= 1'b0;
      losOut  <= 1'b0;
      losIrq  <= 1'b0;
    end else begin
      losDens <= nextDens;
      losOut  <= nextOut;
      losIrq  <= (losIrq && !intClr) || ((nextOut != losOut) && !intMask);
    end
  end

endmodule

// File: rtl/line_los_detector.sv
module line_los_detector
  import line_los_pkg::*;
#(
  parameter int LONG_WIN        = 128,
  parameter int SHORT_WIN       = 32,
  parameter int LONG_MIN_MARKS  = 16,
  parameter int SHORT_MIN_MARKS = 4,
  parameter int LONG_RUN_MAX    = 99,
  parameter int SHORT_RUN_MAX   = 15,
  parameter int T1_DECL         = 175,
  parameter int E1_SHORT_DECL   = 32,
  parameter int E1_LONG_DECL    = 2048
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic rxBit,
  input  logic e1Mode,
  input  logic altStd,
  input  logic hwMode,
  input  logic ampLos,
  input  logic intMask,
  input  logic intClr,
  output logic losOut,
  output logic losStatus,
  output logic losIrq
);

  localparam int RUN_SAT = (E1_LONG_DECL > T1_DECL) ? E1_LONG_DECL : T1_DECL;
  localparam int RUN_W   = $clog2(RUN_SAT + 1);
  localparam int MARK_W  = $clog2(LONG_WIN + 1);

  dpStrobe_t         strobe;
  logic [RUN_W-1:0]  zeroRun;
  logic [MARK_W-1:0] longMarks;
  logic [MARK_W-1:0] shortMarks;
  logic [MARK_W-1:0] cleanAge;

  line_los_datapath #(
    .LONG_WIN(LONG_WIN), .SHORT_WIN(SHORT_WIN),
    .LONG_RUN_MAX(LONG_RUN_MAX), .SHORT_RUN_MAX(SHORT_RUN_MAX),
    .RUN_SAT(RUN_SAT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxBit(rxBit),
    .zeroRun(zeroRun), .longMarks(longMarks),
    .shortMarks(shortMarks), .cleanAge(cleanAge)
  );

  line_los_ctrl #(
    .LONG_WIN(LONG_WIN), .SHORT_WIN(SHORT_WIN),
    .LONG_MIN_MARKS(LONG_MIN_MARKS), .SHORT_MIN_MARKS(SHORT_MIN_MARKS),
    .T1_DECL(T1_DECL), .E1_SHORT_DECL(E1_SHORT_DECL), .E1_LONG_DECL(E1_LONG_DECL),
    .RUN_W(RUN_W), .MARK_W(MARK_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .e1Mode(e1Mode),
    .altStd(altStd), .hwMode(hwMode), .ampLos(ampLos),
    .intMask(intMask), .intClr(intClr),
    .zeroRun(zeroRun), .longMarks(longMarks),
    .shortMarks(shortMarks), .cleanAge(cleanAge),
    .strobe(strobe), .losDens(losStatus), .losOut(losOut), .losIrq(losIrq)
  );

endmodule

// File: rtl/line_los_checker.sv
module line_los_checker (
  input logic clk,
  input logic rstN,
  input logic ampLos,
  input logic intMask,
  input logic intClr,
  input logic losOut,
  input logic losStatus,
  input logic losIrq
);

  AST_AMP_FORCES_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    $past(ampLos) |-> losOut);  // R9

  AST_STATUS_IMPLIES_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    losStatus |-> losOut);  // R9

  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    ((losOut != $past(losOut)) && !$past(intMask)) |-> losIrq);  // R10

  AST_IRQ_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(losIrq) && $past(intMask)) |-> !losIrq);  // R10

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(losIrq) && !$past(intClr)) |-> losIrq);  // R11

  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(losIrq) && (losOut == $past(losOut))) |-> !losIrq);  // R10

endmodule

bind line_los_detector line_los_checker chk_i (.*);

// File: tb/line_los_detector_tb.sv
module line_los_detector_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0, rxBit = 1'b0;
  logic e1Mode = 1'b0, altStd = 1'b0, hwMode = 1'b0;
  logic ampLos = 1'b0, intMask = 1'b0, intClr = 1'b0;
  logic losOut, losStatus, losIrq;

  always #4 clk = ~clk;  // 125 MHz

  line_los_detector dut_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit),
    .e1Mode(e1Mode), .altStd(altStd), .hwMode(hwMode), .ampLos(ampLos),
    .intMask(intMask), .intClr(intClr),
    .losOut(losOut), .losStatus(losStatus), .losIrq(losIrq)
  );

  typedef struct {
    bit    los;
    bit    irq;
    string tag;
  } exp_t;

  exp_t  expQ[$];
  int    checks = 0;
  int    fails  = 0;
  bit    vp1 = 1'b0, vp2 = 1'b0;

  // reference model state
  int    hist[$];
  int    runPos[$];
  int    curRun;
  bit    mLos, mIrq;
  int    mDecl, mWin, mMin, mRunMax;
  string curTag;

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic bit modelClear();
    int marks = 0;
    bit bad = 1'b0;
    if (hist.size() < mWin) return 1'b0;
    for (int i = hist.size() - mWin; i < hist.size(); i++) begin
      marks += hist[i];
      if (runPos[i] > mRunMax) bad = 1'b1;
    end
    return (marks >= mMin) && !bad;
  endfunction

  task automatic sendBit(bit b);
    bit prev;
    @(negedge clk);
    bitValid = 1'b1;
    rxBit    = b;
    hist.push_back(int'(b));
    curRun = b ? 0 : curRun + 1;
    runPos.push_back(curRun);
    prev = mLos;
    if (!mLos) mLos = (curRun >= mDecl);
    else if (modelClear()) mLos = 1'b0;
    if (mLos != prev && !intMask) mIrq = 1'b1;
    expQ.push_back('{mLos, mIrq, curTag});
  endtask

  task automatic sendRun(int n, bit b);
    for (int i = 0; i < n; i++) sendBit(b);
  endtask

  task automatic sendSpaced(int n, int period);
    for (int i = 0; i < n; i++) sendBit((i % period) == (period - 1));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitValid = 1'b0;
      rxBit    = 1'b0;
    end
  endtask

  task automatic startMode(bit e1, bit alt, bit hw);
    idle(3);
    e1Mode = e1; altStd = alt; hwMode = hw;
    if (!e1) begin
      mDecl = 175; mWin = 128; mMin = 16; mRunMax = 99;
    end else if (alt && !hw) begin
      mDecl = 2048; mWin = 32; mMin = 4; mRunMax = 15;
    end else begin
      mDecl = 32; mWin = 32; mMin = 4; mRunMax = 15;
    end
    rstN = 1'b0;
    hist.delete(); runPos.delete();
    curRun = 0; mLos = 1'b0; mIrq = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  // scoreboard monitor: a bit's result is due two edges after it is accepted
  always @(posedge clk) begin
    vp1 <= bitValid && rstN;
    vp2 <= vp1;
  end

  always @(negedge clk) begin
    if (vp2) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard result with empty queue actual=%0b expected=none", losOut);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(e.tag, "losOut", losOut, e.los);
        chk(e.tag, "losStatus", losStatus, e.los);
        chk(e.tag, "losIrq", losIrq, e.irq);
      end
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    // ---- T1 criterion ----
    startMode(1'b0, 1'b0, 1'b0);
    chk("R1", "losOut", losOut, 1'b0);
    chk("R1", "losStatus", losStatus, 1'b0);
    chk("R1", "losIrq", losIrq, 1'b0);

    curTag = "R2";
    sendRun(40, 1'b1);
    sendRun(174, 1'b0);
    idle(40);  // R8: idle cycles with rxBit low must not extend the run
    chk("R8", "losOut after idle", losOut, 1'b0);
    sendBit(1'b0);          // 175th zero declares loss
    idle(3);
    chk("R2", "losOut after 175 zeros", losOut, 1'b1);

    curTag = "R3";
    sendSpaced(120, 8);     // 15 marks: stays in loss
    sendSpaced(140, 8);     // enough marks: clears
    idle(3);
    chk("R3", "cleared by density", losOut, 1'b0);
    sendRun(175, 1'b0);     // loss again
    sendSpaced(64, 4);      // 16 marks
    sendRun(100, 1'b0);     // over-long run inside window
    sendSpaced(160, 4);     // clears only after run leaves window
    idle(3);
    chk("R3", "cleared after long run aged out", losOut, 1'b0);

    // ---- short E1 criterion ----
    startMode(1'b1, 1'b0, 1'b0);
    curTag = "R4";
    sendRun(10, 1'b1);
    sendRun(31, 1'b0);
    sendBit(1'b1);
    sendRun(32, 1'b0);
    curTag = "R5";
    sendSpaced(40, 8);
    sendRun(16, 1'b0);      // run past limit while loss already cleared? no: declare needs 32
    sendSpaced(24, 8);
    sendRun(32, 1'b0);      // loss
    sendSpaced(20, 8);      // 2 marks: stays
    sendRun(16, 1'b0);
    sendSpaced(48, 8);
    idle(3);
    chk("R5", "cleared under 4-of-32", losOut, 1'b0);

    // ---- long E1 criterion ----
    startMode(1'b1, 1'b1, 1'b0);
    curTag = "R6";
    sendRun(8, 1'b1);
    sendRun(2047, 1'b0);
    idle(3);
    chk("R6", "no loss at 2047 zeros", losOut, 1'b0);
    sendBit(1'b0);
    idle(3);
    chk("R6", "loss at 2048 zeros", losOut, 1'b1);
    sendSpaced(40, 8);
    idle(3);
    chk("R6", "cleared under 4-of-32", losOut, 1'b0);

    // ---- restricted selection ----
    startMode(1'b1, 1'b1, 1'b1);
    curTag = "R7";
    sendRun(8, 1'b1);
    sendRun(32, 1'b0);
    idle(3);
    chk("R7", "short criterion forced", losOut, 1'b1);

    // ---- amplitude input and interrupt flag ----
    startMode(1'b0, 1'b0, 1'b0);
    curTag = "R9";
    sendRun(20, 1'b1);
    idle(3);
    ampLos = 1'b1;
    @(negedge clk);
    chk("R9", "losOut from ampLos", losOut, 1'b1);
    chk("R9", "losStatus density only", losStatus, 1'b0);
    chk("R10", "irq on rise", losIrq, 1'b1);
    ampLos = 1'b0;
    @(negedge clk);
    chk("R9", "losOut after ampLos low", losOut, 1'b0);
    chk("R11", "irq sticky", losIrq, 1'b1);
    intClr = 1'b1;
    @(negedge clk);
    chk("R11", "irq cleared", losIrq, 1'b0);
    ampLos = 1'b1;          // change and clear on same edge
    @(negedge clk);
    chk("R11", "set wins over clear", losIrq, 1'b1);
    ampLos = 1'b0;
    intClr = 1'b0;
    intMask = 1'b1;
    @(negedge clk);
    intClr = 1'b1;
    @(negedge clk);
    chk("R11", "irq cleared again", losIrq, 1'b0);
    intClr = 1'b0;
    ampLos = 1'b1;
    @(negedge clk);
    chk("R10", "masked rise losOut", losOut, 1'b1);
    chk("R10", "masked rise irq", losIrq, 1'b0);
    ampLos = 1'b0;
    @(negedge clk);
    chk("R10", "masked fall irq", losIrq, 1'b0);
    intMask = 1'b0;
    idle(3);

    finishRun();
  end

endmodule